// File: doc/BRIEF.md
# FIFO Threshold and Drain Interrupt Unit

This block sits between a host register port and a serial byte engine of a two-wire bus controller. It holds a transmit byte FIFO, filled by host data writes and emptied by the engine, and a receive byte FIFO, filled by the engine and emptied by host data reads. From the FIFO levels, two programmable thresholds and the number of bytes still owed in the current transfer, it raises four sticky data-request flags.

In a transmit transfer, the "ready" flag asks the host for a full threshold's worth of bytes. The "drain" flag tells it that the bytes still to be written can no longer bring the FIFO up to the threshold. In a receive transfer, the "ready" flag reports that the threshold has been reached. The "drain" flag reports that the last byte has arrived and the threshold will not be reached, so the host should collect whatever is left.

A transfer begins with a start strobe that carries the direction and the byte count. A configuration word sets both thresholds as value-minus-one and can flush either FIFO. The host clears flags by writing ones to their bit positions.

Top module: `drain_fifo_irq`

## Requirements
- R1: A configuration write takes the TX threshold minus one from bits [5:0] and the RX threshold minus one from bits [13:8], so each threshold is the field value plus one. A 1 in bit 6 empties the TX FIFO, and a 1 in bit 14 empties the RX FIFO. After reset both fields are 0.
- R2: During a receive transfer, the receive-ready flag (status bit 2) is set whenever the RX level is at or above the RX threshold.
- R3: During a receive transfer, the receive-drain flag (status bit 3) is set when no bytes are still owed, the RX level is nonzero and the RX level is below the RX threshold. It is never set while the threshold is met.
- R4: During a transmit transfer with bytes still owed, the transmit-ready flag (status bit 0) is set when the TX level is below the TX threshold and the level plus the owed count reaches the threshold.
- R5: During a transmit transfer with bytes still owed, the transmit-drain flag (status bit 1) is set when the TX level plus the owed count is below the TX threshold. With nothing owed, neither transmit flag is raised.
- R6: A status-clear strobe clears each flag whose bit is 1 in the clear mask. A flag whose condition still holds in that cycle stays set.
- R7: A start strobe clears all four flags, loads the owed count from the transfer length, and latches the direction (1 = receive). The owed count falls by one for each accepted host write in transmit mode, or for each accepted engine byte in receive mode, and stops at zero.
- R8: Both FIFOs are first-in first-out. Host and engine take data from bits [7:0]. The read port shows the head byte in bits [7:0] with upper bits zero before the read strobe pops it, and reads 0 when the FIFO is empty.
- R9: A host write to a full TX FIFO, an engine pop of an empty TX FIFO, and a host read of an empty RX FIFO are ignored. An engine byte is dropped when the RX FIFO is full, when the transfer is not a receive transfer, or when nothing is owed.
- R10: FIFO depth is 8 << DEPTH_CODE bytes, and the code is reported on `depth_code`.
- R11: FIFO levels change on the clock edge that samples a strobe. Flags change on the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host data write strobe (push TX FIFO) |
| host_wdata | input | HOST_W | Host write data, byte in [7:0] |
| host_rd | input | 1 | Host data read strobe (pop RX FIFO) |
| host_rdata | output | HOST_W | RX FIFO head byte, zero-extended |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | HOST_W | Thresholds and FIFO flush bits |
| stat_clr | input | 1 | Status clear strobe |
| stat_clr_bits | input | 4 | Write-one-to-clear mask for the flags |
| xfer_start | input | 1 | Transfer start strobe |
| xfer_rx | input | 1 | Direction of the starting transfer, 1 = receive |
| xfer_len | input | CNT_W | Byte count of the starting transfer |
| eng_tx_pop | input | 1 | Engine took the TX head byte |
| eng_tx_byte | output | 8 | TX FIFO head byte |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_byte | input | 8 | Received byte |
| stat_flags | output | 4 | Flags: [0] TX ready, [1] TX drain, [2] RX ready, [3] RX drain |
| tx_level | output | LW | TX FIFO fill level |
| rx_level | output | LW | RX FIFO fill level |
| depth_code | output | 2 | Encoded FIFO depth |

## Verification
Levels, the owed count, the head bytes and the start-driven clearing of the flags are all due on the edge that samples the strobe. A condition-driven flag is due one edge later, because it is computed from the registered levels. Every strobe is driven for one cycle from a falling edge, and levels and data are read at the next falling edge. Flag values are read one falling edge later. One check samples the flags in the intervening cycle to confirm they have not yet moved.

// File: rtl/dfi_pkg.sv
package dfi_pkg;
   // flag bit positions in the status word
   localparam int F_XRDY = 0;
   localparam int F_XDR  = 1;
   localparam int F_RRDY = 2;
   localparam int F_RDR  = 3;
   localparam int NFLAG  = 4;

   // configuration word layout
   localparam int THR_W      = 6;
   localparam int TXTHR_LSB  = 0;
   localparam int TXCLR_BIT  = 6;
   localparam int RXTHR_LSB  = 8;
   localparam int RXCLR_BIT  = 14;
   localparam int CFG_MIN_W  = 15;

   function automatic int depth_of(input int code);
      return 8 << code;
   endfunction
endpackage

// File: rtl/dfi_byte_fifo.sv
module dfi_byte_fifo #(
   parameter int DEPTH = 16,
   localparam int AW = $clog2(DEPTH),
   localparam int LW = AW + 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          flush,
   input  logic          push,
   input  logic [7:0]    din,
   input  logic          pop,
   output logic [7:0]    dout,
   output logic [LW-1:0] level,
   output logic          full,
   output logic          empty
);
   generate
      if ((DEPTH < 2) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
         $error("dfi_byte_fifo: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [7:0]    mem [DEPTH];
   logic [AW-1:0] wr_ptr, rd_ptr;
   logic [LW-1:0] cnt_q;
   logic          do_push, do_pop;

   assign full    = (cnt_q == LW'(DEPTH));
   assign empty   = (cnt_q == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else if (flush) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         cnt_q  <= '0;
      end else begin
         if (do_push) wr_ptr <= wr_ptr + AW'(1);
         if (do_pop)  rd_ptr <= rd_ptr + AW'(1);
         cnt_q <= cnt_q + LW'(do_push) - LW'(do_pop);
      end
   end

   always_ff @(posedge clk) begin
      if (!flush && do_push) mem[wr_ptr] <= din;
   end

   assign dout  = empty ? 8'h00 : mem[rd_ptr];
   assign level = cnt_q;
endmodule

// File: rtl/dfi_xfer_track.sv
module dfi_xfer_track #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             start_rx,
   input  logic [CNT_W-1:0] len,
   input  logic             host_take,
   input  logic             bus_take,
   output logic             is_rx,
   output logic [CNT_W-1:0] owed
);
   logic take;

   assign take = is_rx ? bus_take : host_take;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         is_rx <= 1'b0;
         owed  <= '0;
      end else if (start) begin
         is_rx <= start_rx;
         owed  <= len;
      end else if (take && (owed != '0)) begin
         owed  <= owed - CNT_W'(1);
      end
   end
endmodule

// File: rtl/dfi_irq_flags.sv
module dfi_irq_flags
   import dfi_pkg::*;
#(
   parameter int LW    = 5,
   parameter int CNT_W = 16,
   localparam int TW   = THR_W + 1,
   localparam int CW   = ((CNT_W > LW) ? CNT_W : LW) + 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             is_rx,
   input  logic [CNT_W-1:0] owed,
   input  logic [LW-1:0]    tx_level,
   input  logic [LW-1:0]    rx_level,
   input  logic [TW-1:0]    tx_thr,
   input  logic [TW-1:0]    rx_thr,
   input  logic             start,
   input  logic             clr,
   input  logic [NFLAG-1:0] clr_bits,
   output logic [NFLAG-1:0] flags
);
   logic [CW-1:0]    owed_e, txl_e, rxl_e, txt_e, rxt_e, tx_reach;
   logic [NFLAG-1:0] cond;

   assign owed_e   = CW'(owed);
   assign txl_e    = CW'(tx_level);
   assign rxl_e    = CW'(rx_level);
   assign txt_e    = CW'(tx_thr);
   assign rxt_e    = CW'(rx_thr);
   assign tx_reach = txl_e + owed_e;

   always_comb begin
      cond         = '0;
      cond[F_XRDY] = !is_rx && (owed_e != '0) && (txl_e < txt_e) && (tx_reach >= txt_e);
      cond[F_XDR]  = !is_rx && (owed_e != '0) && (tx_reach < txt_e);
      cond[F_RRDY] = is_rx && (rxl_e >= rxt_e);
      cond[F_RDR]  = is_rx && (owed_e == '0) && (rxl_e != '0) && (rxl_e < rxt_e);
   end

   genvar gi;
   generate
      for (gi = 0; gi < NFLAG; gi++) begin : g_flag
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     flags[gi] <= 1'b0;
            else if (start) flags[gi] <= 1'b0;
            else            flags[gi] <= (flags[gi] & ~(clr & clr_bits[gi])) | cond[gi];
         end
      end
   endgenerate
endmodule

// File: rtl/drain_fifo_irq.sv
module drain_fifo_irq
   import dfi_pkg::*;
#(
   parameter int DEPTH_CODE = 1,
   parameter int CNT_W      = 16,
   parameter int HOST_W     = 16,
   localparam int DEPTH     = 8 << DEPTH_CODE,
   localparam int LW        = $clog2(DEPTH) + 1,
   localparam int TW        = THR_W + 1,
   localparam int DCW       = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_wr,
   input  logic [HOST_W-1:0] host_wdata,
   input  logic              host_rd,
   output logic [HOST_W-1:0] host_rdata,
   input  logic              cfg_wr,
   input  logic [HOST_W-1:0] cfg_wdata,
   input  logic              stat_clr,
   input  logic [NFLAG-1:0]  stat_clr_bits,
   input  logic              xfer_start,
   input  logic              xfer_rx,
   input  logic [CNT_W-1:0]  xfer_len,
   input  logic              eng_tx_pop,
   output logic [7:0]        eng_tx_byte,
   input  logic              eng_rx_push,
   input  logic [7:0]        eng_rx_byte,
   output logic [NFLAG-1:0]  stat_flags,
   output logic [LW-1:0]     tx_level,
   output logic [LW-1:0]     rx_level,
   output logic [DCW-1:0]    depth_code
);
   generate
      if ((DEPTH_CODE < 0) || (DEPTH_CODE > 3)) begin : g_bad_code
         $error("drain_fifo_irq: DEPTH_CODE must lie in 0..3");
      end
      if (HOST_W < CFG_MIN_W) begin : g_bad_host
         $error("drain_fifo_irq: HOST_W too narrow for the configuration word");
      end
      if (CNT_W < 1) begin : g_bad_cnt
         $error("drain_fifo_irq: CNT_W must be positive");
      end
   endgenerate

   // threshold configuration, stored as value minus one
   logic [THR_W-1:0] tx_thr_m1, rx_thr_m1;
   logic [TW-1:0]    tx_thr, rx_thr;
   logic             tx_flush, rx_flush;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_thr_m1 <= '0;
         rx_thr_m1 <= '0;
      end else if (cfg_wr) begin
         tx_thr_m1 <= cfg_wdata[TXTHR_LSB +: THR_W];
         rx_thr_m1 <= cfg_wdata[RXTHR_LSB +: THR_W];
      end
   end

   assign tx_thr   = TW'(tx_thr_m1) + TW'(1);
   assign rx_thr   = TW'(rx_thr_m1) + TW'(1);
   assign tx_flush = cfg_wr && cfg_wdata[TXCLR_BIT];
   assign rx_flush = cfg_wr && cfg_wdata[RXCLR_BIT];

   // transfer tracking
   logic             is_rx;
   logic [CNT_W-1:0] owed;
   logic             tx_full, tx_empty, rx_full, rx_empty;
   logic             host_take, bus_take;
   logic [7:0]       rx_head;

   assign host_take = host_wr && !tx_full && !tx_flush;
   assign bus_take  = eng_rx_push && is_rx && (owed != '0) && !rx_full
                      && !xfer_start && !rx_flush;

   dfi_xfer_track #(.CNT_W(CNT_W)) u_track (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (xfer_start),
      .start_rx  (xfer_rx),
      .len       (xfer_len),
      .host_take (host_take),
      .bus_take  (bus_take),
      .is_rx     (is_rx),
      .owed      (owed)
   );

   dfi_byte_fifo #(.DEPTH(DEPTH)) u_txq (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (tx_flush),
      .push  (host_wr),
      .din   (host_wdata[7:0]),
      .pop   (eng_tx_pop),
      .dout  (eng_tx_byte),
      .level (tx_level),
      .full  (tx_full),
      .empty (tx_empty)
   );

   dfi_byte_fifo #(.DEPTH(DEPTH)) u_rxq (
      .clk   (clk),
      .rst_n (rst_n),
      .flush (rx_flush),
      .push  (bus_take),
      .din   (eng_rx_byte),
      .pop   (host_rd),
      .dout  (rx_head),
      .level (rx_level),
      .full  (rx_full),
      .empty (rx_empty)
   );

   assign host_rdata = HOST_W'(rx_head);

   dfi_irq_flags #(.LW(LW), .CNT_W(CNT_W)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .is_rx    (is_rx),
      .owed     (owed),
      .tx_level (tx_level),
      .rx_level (rx_level),
      .tx_thr   (tx_thr),
      .rx_thr   (rx_thr),
      .start    (xfer_start),
      .clr      (stat_clr),
      .clr_bits (stat_clr_bits),
      .flags    (stat_flags)
   );

   assign depth_code = DCW'(DEPTH_CODE);
endmodule

// File: rtl/dfi_checker.sv
module dfi_checker
   import dfi_pkg::*;
#(
   parameter int DEPTH  = 16,
   parameter int LW     = 5,
   parameter int CNT_W  = 16,
   parameter int HOST_W = 16,
   localparam int TW    = THR_W + 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              xfer_start,
   input logic              is_rx,
   input logic [CNT_W-1:0]  owed,
   input logic [LW-1:0]     tx_level,
   input logic [LW-1:0]     rx_level,
   input logic [TW-1:0]     rx_thr,
   input logic [NFLAG-1:0]  stat_flags,
   input logic              cfg_wr,
   input logic [HOST_W-1:0] cfg_wdata
);
   // R9
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_level <= LW'(DEPTH)) && (rx_level <= LW'(DEPTH)));

   // R7
   start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_start |=> (stat_flags == '0));

   // R2
   rx_ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!xfer_start && is_rx && (TW'(rx_level) >= rx_thr)) |=> stat_flags[F_RRDY]);

   // R3
   rx_drain_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_flags[F_RDR]) |-> $past(is_rx && (owed == '0)));

   // R4
   tx_ready_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_flags[F_XRDY]) |-> $past(!is_rx && (owed != '0)));

   // R1
   tx_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_wr && cfg_wdata[TXCLR_BIT]) |=> (tx_level == '0));
endmodule

bind drain_fifo_irq dfi_checker #(
   .DEPTH(DEPTH), .LW(LW), .CNT_W(CNT_W), .HOST_W(HOST_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .xfer_start (xfer_start),
   .is_rx      (is_rx),
   .owed       (owed),
   .tx_level   (tx_level),
   .rx_level   (rx_level),
   .rx_thr     (rx_thr),
   .stat_flags (stat_flags),
   .cfg_wr     (cfg_wr),
   .cfg_wdata  (cfg_wdata)
);

// File: tb/drain_fifo_irq_bench.sv
module drain_fifo_irq_bench;
   localparam int LW = 5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        host_wr = 0, host_rd = 0, cfg_wr = 0, stat_clr = 0;
   logic [15:0] host_wdata = '0, cfg_wdata = '0;
   logic [15:0] host_rdata;
   logic [3:0]  stat_clr_bits = '0;
   logic        xfer_start = 0, xfer_rx = 0;
   logic [15:0] xfer_len = '0;
   logic        eng_tx_pop = 0, eng_rx_push = 0;
   logic [7:0]  eng_tx_byte, eng_rx_byte = '0;
   logic [3:0]  stat_flags;
   logic [LW-1:0] tx_level, rx_level;
   logic [1:0]  depth_code;

   int total = 0;
   int bad   = 0;

   always #10 clk = ~clk;

   drain_fifo_irq u_drain_fifo_irq (
      .clk(clk), .rst_n(rst_n),
      .host_wr(host_wr), .host_wdata(host_wdata),
      .host_rd(host_rd), .host_rdata(host_rdata),
      .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
      .stat_clr(stat_clr), .stat_clr_bits(stat_clr_bits),
      .xfer_start(xfer_start), .xfer_rx(xfer_rx), .xfer_len(xfer_len),
      .eng_tx_pop(eng_tx_pop), .eng_tx_byte(eng_tx_byte),
      .eng_rx_push(eng_rx_push), .eng_rx_byte(eng_rx_byte),
      .stat_flags(stat_flags), .tx_level(tx_level), .rx_level(rx_level),
      .depth_code(depth_code)
   );

   // receive cases: rx threshold, length, pushes, expected level, expected flags
   localparam int NV = 7;
   localparam int RXV [NV][5] = '{
      '{4, 8, 3, 3, 0},
      '{4, 8, 4, 4, 4},
      '{4, 3, 3, 3, 8},
      '{1, 2, 1, 1, 4},
      '{8, 5, 5, 5, 8},
      '{5, 10, 7, 7, 4},
      '{4, 2, 4, 2, 8}
   };

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic cfg_write(input logic [15:0] d);
      cfg_wdata = d; cfg_wr = 1'b1; @(negedge clk); cfg_wr = 1'b0;
   endtask

   task automatic start(input logic rx, input int len);
      xfer_rx = rx; xfer_len = 16'(len); xfer_start = 1'b1;
      @(negedge clk); xfer_start = 1'b0;
   endtask

   task automatic hwrite(input logic [15:0] d);
      host_wdata = d; host_wr = 1'b1; @(negedge clk); host_wr = 1'b0;
   endtask

   task automatic hread();
      host_rd = 1'b1; @(negedge clk); host_rd = 1'b0;
   endtask

   task automatic tpop();
      eng_tx_pop = 1'b1; @(negedge clk); eng_tx_pop = 1'b0;
   endtask

   task automatic rpush(input logic [7:0] b);
      eng_rx_byte = b; eng_rx_push = 1'b1; @(negedge clk); eng_rx_push = 1'b0;
   endtask

   task automatic sclear(input logic [3:0] m);
      stat_clr_bits = m; stat_clr = 1'b1; @(negedge clk); stat_clr = 1'b0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();
      // reset state
      chk("R7 reset flags", int'(stat_flags), 0);
      chk("R9 reset tx level", int'(tx_level), 0);
      chk("R9 reset rx level", int'(rx_level), 0);
      chk("R10 depth code", int'(depth_code), 1);
      chk("R8 empty read", int'(host_rdata), 0);

      // receive threshold and drain table (R1 R2 R3 R9)
      for (int i = 0; i < NV; i++) begin
         cfg_write(16'((RXV[i][0] - 1) << 8) | 16'h4040);
         start(1'b1, RXV[i][1]);
         for (int k = 0; k < RXV[i][2]; k++) rpush(8'(k + 1));
         tick();
         chk("R1 R9 rx level", int'(rx_level), RXV[i][3]);
         chk("R2 R3 rx flags", int'(stat_flags), RXV[i][4]);
      end

      // transmit path
      cfg_write(16'h4043);
      start(1'b0, 10);
      tick();
      chk("R4 tx ready on start", int'(stat_flags), 1);
      hwrite(16'hAB11); hwrite(16'hAB22); hwrite(16'hAB33); hwrite(16'hAB44);
      chk("R11 tx level", int'(tx_level), 4);
      tick();
      sclear(4'b0001);
      chk("R6 clear tx ready", int'(stat_flags), 0);
      chk("R8 tx head", int'(eng_tx_byte), 'h11);
      tpop(); tpop();
      chk("R8 tx order", int'(eng_tx_byte), 'h33);
      tick();
      chk("R4 tx ready refill", int'(stat_flags), 1);
      hwrite(16'h0055); hwrite(16'h0066); hwrite(16'h0077); hwrite(16'h0088);
      for (int k = 0; k < 5; k++) tpop();
      tick();
      chk("R5 tx drain", int'(stat_flags), 3);
      sclear(4'b0001);
      chk("R5 drain only", int'(stat_flags), 2);
      sclear(4'b0010);
      chk("R6 clear while held", int'(stat_flags), 2);
      hwrite(16'h0099); hwrite(16'h00AA);
      chk("R7 owed writes", int'(tx_level), 3);
      tick();
      sclear(4'b0011);
      chk("R5 nothing owed", int'(stat_flags), 0);
      chk("R8 tx head later", int'(eng_tx_byte), 'h88);
      cfg_write(16'h0043);
      chk("R1 tx flush", int'(tx_level), 0);
      tpop();
      chk("R9 pop empty", int'(tx_level), 0);
      start(1'b0, 40);
      for (int k = 0; k < 18; k++) hwrite(16'(k));
      chk("R9 R10 tx full", int'(tx_level), 16);

      // receive path directed
      cfg_write(16'h4143);
      start(1'b1, 3);
      rpush(8'hA5);
      chk("R8 rx zero ext", int'(host_rdata), 'hA5);
      chk("R9 rx level", int'(rx_level), 1);
      rpush(8'h5A);
      chk("R11 flag lag", int'(stat_flags), 0);
      tick();
      chk("R2 rx ready", int'(stat_flags), 4);
      sclear(4'b0100);
      chk("R6 rx ready held", int'(stat_flags), 4);
      hread();
      chk("R8 rx level after read", int'(rx_level), 1);
      chk("R8 rx order", int'(host_rdata), 'h5A);
      sclear(4'b0100);
      chk("R6 rx clear", int'(stat_flags), 0);
      rpush(8'h3C);
      tick();
      chk("R3 no drain at threshold", int'(stat_flags), 4);
      hread();
      tick();
      sclear(4'b0100);
      chk("R3 rx drain", int'(stat_flags), 8);
      rpush(8'hEE);
      chk("R9 rx over owed", int'(rx_level), 1);
      hread(); hread();
      chk("R9 read empty level", int'(rx_level), 0);
      chk("R8 read empty data", int'(host_rdata), 0);
      start(1'b0, 5);
      chk("R7 start clears", int'(stat_flags), 0);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule